// File: doc/BRIEF.md
# Paged Memory Address and Write Controller

This block is the memory side of a two-wire serial memory target. A protocol front end handles bit timing, address matching and acknowledge. It hands this controller one event per clock: the start of an addressed transfer, a received byte, a request for the next read byte, or a stop. The controller keeps the word address counter and loads it from the first two bytes of a write transfer. It collects the data bytes that follow in a one-page staging buffer. Those bytes reach the byte array only after a stop. The commit runs inside a timed write cycle, and for that whole cycle `busy` tells the front end to stop acknowledging.

Reads come from the current counter value. Each accepted read request returns one byte and advances the counter across the whole array. A write advances only the offset within the 64-byte page. Raising the write-protect input blocks every commit. The array holds 2^ADDR_W bytes: ADDR_W is 14 or 15 for the 16K and 32K capacities, and the default is kept small. WR_CYCLES sets the length of the write cycle and must be at least 64.

When more than one event input is high in the same cycle, the controller takes the first of these: transfer start, then write byte, then read request, then stop.

Top module: `eeprom_page_ctl`

## Requirements
- R1: After reset, `busy` and `rd_vld` are 0.
- R2: In a write transfer, the first byte loads counter bits ADDR_W-1..8 from its low ADDR_W-8 bits, and its higher bits are ignored. The second byte loads counter bits 7..0.
- R3: Each further write byte is stored at the counter, and then only counter bits 5..0 increment. From offset 63 the counter wraps to offset 0 of the same page.
- R4: When a transfer sends more than 64 data bytes, each later byte replaces the byte sent earlier at the same offset.
- R5: Data bytes are committed only when a stop ends the transfer. A new transfer start before the stop discards them.
- R6: A stop after at least one data byte, with `wp` low, raises `busy` on the next cycle and holds it for exactly WR_CYCLES cycles. A transfer with no data byte never raises `busy`.
- R7: While `busy` is 1, all event inputs are ignored: no read byte is returned, and the counter and the array do not change.
- R8: When `wp` is 1 at the stop, nothing is written and `busy` stays 0. The counter still advances as in R3.
- R9: A read request accepted at a clock edge gives `rd_vld`=1 and `rd_data` = byte at the counter right after that edge. The counter then increments by one.
- R10: Read increments run over the whole array, from address 2^ADDR_W-1 to address 0.
- R11: Between transfers the counter keeps its value, so a read that sends no address returns the byte after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp | input | 1 | Write protect: 1 blocks all commits |
| xfer_start | input | 1 | Pulse: an addressed transfer begins (start or repeated start) |
| wr_vld | input | 1 | Pulse: a byte was received in a write transfer |
| wr_byte | input | 8 | Received byte |
| rd_req | input | 1 | Pulse: the front end needs the next read byte |
| stop | input | 1 | Pulse: stop condition seen |
| busy | output | 1 | Timed write cycle in progress |
| rd_vld | output | 1 | `rd_data` holds a new read byte this cycle |
| rd_data | output | 8 | Read byte |

## Verification
A read byte is due one cycle after its request. The bench queues the expected byte before the edge that samples the request, and a monitor compares it at the falling edge after that edge. Any `rd_vld` that arrives with the queue empty counts as a failure. `busy` is due in the cycle right after the edge that samples `stop`. The bench counts falling edges with `busy` high, starting at the first falling edge after the stop, and expects exactly WR_CYCLES, or zero for protected and address-only transfers. Array contents are checked only by reading them back after `busy` has dropped.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int PAGE_BYTES = 64;
  localparam int OFS_W      = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    PH_ADDR_HI = 2'd0,
    PH_ADDR_LO = 2'd1,
    PH_DATA    = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr
  import eep_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              xfer_start,
  input  logic              wr_vld,
  input  logic [7:0]        wr_byte,
  input  logic              rd_req,
  input  logic              stop,
  output logic [ADDR_W-1:0] addr,
  output logic              data_we,
  output logic              has_data
);
  wr_phase_e         phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              has_q;

  // a data byte lands in the staging buffer at the current offset
  assign data_we  = en && !xfer_start && wr_vld && (phase_q == PH_DATA);
  assign addr     = addr_q;
  assign has_data = has_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      phase_q <= PH_ADDR_HI;
      has_q   <= 1'b0;
    end else if (en) begin
      if (xfer_start) begin
        phase_q <= PH_ADDR_HI;
        has_q   <= 1'b0;
      end else if (wr_vld) begin
        case (phase_q)
          PH_ADDR_HI: begin
            addr_q[ADDR_W-1:8] <= wr_byte[ADDR_W-9:0];
            phase_q            <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            addr_q[7:0] <= wr_byte;
            phase_q     <= PH_DATA;
          end
          default: begin
            addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + OFS_W'(1);
            has_q             <= 1'b1;
          end
        endcase
      end else if (rd_req) begin
        addr_q <= addr_q + ADDR_W'(1);
      end else if (stop) begin
        phase_q <= PH_ADDR_HI;
        has_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [OFS_W-1:0] wofs,
  input  logic [7:0]       wdata,
  input  logic [OFS_W-1:0] rofs,
  output logic [7:0]       rdata,
  output logic             rvalid
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (we)    vld_q[wofs] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) slot_q[wofs] <= wdata;
  end

  assign rdata  = slot_q[rofs];
  assign rvalid = vld_q[rofs];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer
  import eep_pkg::*;
#(
  parameter int WR_CYCLES = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output logic             busy,
  output logic             commit_en,
  output logic [OFS_W-1:0] commit_ofs
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OFS_W:0]   idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (launch) begin
      cnt_q <= CNT_W'(WR_CYCLES);
      idx_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (!idx_q[OFS_W]) idx_q <= idx_q + (OFS_W+1)'(1);
    end
  end

  // the commit walk covers all page slots within the first 64 busy cycles
  assign busy       = (cnt_q != '0);
  assign commit_en  = busy && !idx_q[OFS_W];
  assign commit_ofs = idx_q[OFS_W-1:0];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wp,
  input  logic       xfer_start,
  input  logic       wr_vld,
  input  logic [7:0] wr_byte,
  input  logic       rd_req,
  input  logic       stop,
  output logic       busy,
  output logic       rd_vld,
  output logic [7:0] rd_data
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] addr;
  logic              data_we, has_data, accept, launch, rd_take;
  logic              commit_en, slot_vld;
  logic [OFS_W-1:0]  commit_ofs;
  logic [7:0]        slot_data;
  logic [PAGE_W-1:0] page_q;
  logic              rd_vld_q;

  assign accept  = !busy;
  assign launch  = accept && !xfer_start && !wr_vld && !rd_req && stop && has_data && !wp;
  assign rd_take = accept && !xfer_start && !wr_vld && rd_req;

  eep_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .en(accept), .xfer_start(xfer_start),
    .wr_vld(wr_vld), .wr_byte(wr_byte), .rd_req(rd_req), .stop(stop),
    .addr(addr), .data_we(data_we), .has_data(has_data)
  );

  eep_page_buf u_buf (
    .clk(clk), .rst(rst), .clr(accept && xfer_start), .we(data_we),
    .wofs(addr[OFS_W-1:0]), .wdata(wr_byte), .rofs(commit_ofs),
    .rdata(slot_data), .rvalid(slot_vld)
  );

  eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .launch(launch), .busy(busy),
    .commit_en(commit_en), .commit_ofs(commit_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst)         page_q <= '0;
    else if (launch) page_q <= addr[ADDR_W-1:OFS_W];
  end

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(commit_en && slot_vld), .waddr({page_q, commit_ofs}),
    .wdata(slot_data), .re(rd_take), .raddr(addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= rd_take;
  end
  assign rd_vld = rd_vld_q;
endmodule

// File: rtl/eeprom_page_ctl_chk.sv
module eeprom_page_ctl_chk #(
  parameter int WR_CYCLES = 80
) (
  input logic clk,
  input logic rst,
  input logic wp,
  input logic rd_req,
  input logic stop,
  input logic busy,
  input logic rd_vld
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  // R9: a read byte only follows an accepted request
  p_rd_cause_r9: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(rd_req) && !$past(busy)));

  // R7: requests during the write cycle return nothing
  p_no_read_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_req) |=> !rd_vld);

  // R6: the write cycle starts only from a stop
  p_busy_from_stop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop));

  // R6: the write cycle lasts exactly WR_CYCLES
  p_busy_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == WR_CYCLES));

  // R8: a protected stop never starts a write cycle
  p_wp_no_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (stop && wp && !busy) |=> !busy);
endmodule

bind eeprom_page_ctl eeprom_page_ctl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wp(wp), .rd_req(rd_req), .stop(stop),
  .busy(busy), .rd_vld(rd_vld)
);

// File: tb/eeprom_page_ctl_bench.sv
module eeprom_page_ctl_bench;
  localparam int AW    = 11;
  localparam int WR    = 80;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0, rst = 1'b1, wp = 1'b0;
  logic       xfer_start = 1'b0, wr_vld = 1'b0, rd_req = 1'b0, stop = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       busy, rd_vld;
  logic [7:0] rd_data;

  int         checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [AW-1:0] mctr = '0;
  logic [7:0] expq [$];
  string      tag = "R9";
  bit         done = 1'b0;

  always #4 clk = ~clk;

  eeprom_page_ctl #(.ADDR_W(AW), .WR_CYCLES(WR)) u_eeprom_page_ctl (
    .clk(clk), .rst(rst), .wp(wp), .xfer_start(xfer_start), .wr_vld(wr_vld),
    .wr_byte(wr_byte), .rd_req(rd_req), .stop(stop), .busy(busy),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one expected byte per returned read byte (R9)
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (expq.size() == 0) check(1'b0, {tag, " unexpected read byte"}, rd_data, 0);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        check(rd_data === e, tag, rd_data, e);
      end
    end
  end

  task automatic ev_start();
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
  endtask
  task automatic ev_byte(input logic [7:0] b);
    wr_vld = 1'b1; wr_byte = b; @(negedge clk); wr_vld = 1'b0;
  endtask
  task automatic ev_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  function automatic logic [AW-1:0] map_addr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[AW-9:0], lo};
  endfunction

  // write transfer; the model takes the data only when a stop ends it unprotected
  task automatic write_xfer(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] data [$], input bit end_stop);
    logic [AW-1:0] a [$];
    ev_start(); ev_byte(hi); ev_byte(lo);
    mctr = map_addr(hi, lo);
    foreach (data[i]) begin
      ev_byte(data[i]);
      a.push_back(mctr);
      mctr = {mctr[AW-1:6], 6'(mctr[5:0] + 6'd1)};
    end
    if (end_stop) begin
      ev_stop();
      if (!wp) foreach (data[i]) model[a[i]] = data[i];
    end
  endtask

  task automatic busy_len(input int exp, input string req);
    int n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    check(n == exp, req, n, exp);
  endtask

  task automatic read_n(input int n, input string req);
    tag = req;
    ev_start();
    for (int i = 0; i < n; i++) begin
      expq.push_back(model[mctr]);
      mctr = mctr + AW'(1);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
      check(rd_vld === 1'b1, "R9 rd_vld one cycle after request", rd_vld, 1);
    end
    ev_stop();
  endtask

  task automatic rand_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    ev_start(); ev_byte(hi); ev_byte(lo);
    mctr = map_addr(hi, lo);
    read_n(n, req);
  endtask

  task automatic finish_run();
    check(expq.size() == 0, "R9 all expected reads returned", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d [$];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy after reset", busy, 0);
    check(rd_vld === 1'b0, "R1 rd_vld after reset", rd_vld, 0);

    // R6 timed cycle; R3 in-page write
    d = '{8'h11, 8'h22, 8'h33};
    write_xfer(8'h00, 8'h12, d, 1'b1);
    busy_len(WR, "R6 busy length");
    rand_read(8'h00, 8'h12, 3, "R3 byte sequence");

    // R3 page wrap: 0x13E.. wraps to 0x100; 0x140 untouched
    d = '{8'h77};
    write_xfer(8'h01, 8'h40, d, 1'b1); busy_len(WR, "R6 busy length");
    d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    write_xfer(8'h01, 8'h3E, d, 1'b1); busy_len(WR, "R6 busy length");
    rand_read(8'h01, 8'h3E, 2, "R3 page end");
    rand_read(8'h01, 8'h00, 2, "R3 wrap to page start");
    rand_read(8'h01, 8'h40, 1, "R3 next page untouched");

    // R6 address-only transfer starts no write cycle
    d = {};
    write_xfer(8'h01, 8'h3F, d, 1'b1);
    busy_len(0, "R6 no data no busy");
    read_n(1, "R11 read after address-only write");

    // R4 overrun; R7 ignored events during busy; R11 current address
    d = {};
    for (int i = 0; i < 66; i++) d.push_back(8'(i * 3 + 1));
    write_xfer(8'h02, 8'h00, d, 1'b1);
    check(busy === 1'b1, "R6 busy after stop", busy, 1);
    ev_start(); ev_byte(8'h02); ev_byte(8'h00); ev_byte(8'hEE);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    check(rd_vld === 1'b0, "R7 no read while busy", rd_vld, 0);
    ev_stop();
    while (busy) @(negedge clk);
    read_n(3, "R11 current address after page write");
    rand_read(8'h02, 8'h00, 4, "R4 overrun overwrites");

    // R5 restart discards data
    ev_start(); ev_byte(8'h01); ev_byte(8'h00); ev_byte(8'h99);
    mctr = 11'h101;
    ev_start(); ev_stop();
    busy_len(0, "R5 restart no busy");
    rand_read(8'h01, 8'h00, 1, "R5 discarded data");

    // R8 write protect
    wp = 1'b1;
    d = '{8'h42};
    write_xfer(8'h01, 8'h00, d, 1'b1);
    busy_len(0, "R8 protected no busy");
    read_n(1, "R8 counter advanced under protect");
    wp = 1'b0;
    rand_read(8'h01, 8'h00, 1, "R8 protected byte unchanged");

    // R2 upper address bits ignored
    d = '{8'h3C};
    write_xfer(8'hF9, 8'h05, d, 1'b1); busy_len(WR, "R6 busy length");
    rand_read(8'h01, 8'h05, 1, "R2 high bits ignored");

    // R10 read wrap across array end
    d = '{8'hD1, 8'hD2};
    write_xfer(8'h07, 8'hFE, d, 1'b1); busy_len(WR, "R6 busy length");
    d = '{8'hD3};
    write_xfer(8'h00, 8'h00, d, 1'b1); busy_len(WR, "R6 busy length");
    rand_read(8'h07, 8'hFE, 3, "R10 wrap to address 0");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule